// File: doc/BRIEF.md
# Programmable-Rate Multichannel Input Debouncer

This block cleans up a bank of 30 slow digital input lines. Every line first passes through a two-flop synchronizer. All synchronized lines are then sampled together on one shared sampling tick. That tick comes from the system clock through a power-of-two prescaler. A line's bit in the input data register takes a new value only when two samples in a row of that line agree. A pulse shorter than one sampling period can therefore never reach the data register.

Software drives the block through a simple synchronous register port with an address, a write strobe, 32-bit write data and combinational 32-bit read data. Word address 0 holds the control register and word address 1 holds the debounced input data. The control register carries a master enable bit and a 3-bit rate select. It also carries three enable flags for event, latch and pattern features. Those three flags are stored and read back but drive no logic in this block.

Top module: `din_debounce`

## Requirements
- R1: After reset, a read of the control register (word address 0) returns 0, and a read of the data register (word address 1) returns 0.
- R2: Control bits 7:4 and 2:0 are read/write. Bit 3 and bits 31:8 always read 0 and ignore writes. At the data address, bits 29:0 hold channels 29..0 and bits 31:30 read 0.
- R3: A write to the data address (word address 1) changes neither the data register nor the control register.
- R4: Control bit 7 is the enable. While it is 0, no sampling tick occurs and the data register holds its value whatever the inputs do.
- R5: Control bits 2:0 select the sampling period in clock cycles: 000 gives 1 cycle, and a nonzero value k gives 2^(6+2k) cycles (001 gives 256, 010 gives 1024, and so on up to 111 giving 2^20).
- R6: One shared tick samples all 30 channels at once, so channels whose inputs change together update in the same cycle.
- R7: A channel's data bit changes only on a tick where that channel's sample equals its sample from the previous tick. With select 000, a one-cycle input pulse is rejected and a two-cycle pulse is accepted.
- R8: With select 001, a pulse shorter than 256 cycles never reaches the data register, while a steady level is taken within two periods plus the synchronizer delay.
- R9: Any write to the control register restarts the prescaler. When the enable is set and the select is nonzero, the first tick comes one full period (N cycles) after the write edge, and the second comes at 2N cycles. A steady new level therefore appears exactly 2N cycles after the write.
- R10: With select 000 and the enable set, an input change made before clock edge E0 is absent from the data register after edge E2 and present after edge E3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_i | input | 30 | Raw input lines, asynchronous to clk_i |
| addr_i | input | 2 | Register word address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |

## Verification
The bench measures the exact edge at which a steady level reaches the data register after a control write. It does this at the 256- and 1024-cycle rates, and again after a second write lands partway through a period. A prescaler that kept counting across the rewrite would take the level about 200 cycles early, and one with a wrong divider table would miss the 2N edge. Glitches one cycle wide and 200 cycles wide are applied to show that a filter accepting a single sample would let them through. A two-cycle pulse is applied to show that the filter still passes legitimate short levels. The bench also checks three things: inputs changed while disabled must not leak through, writes to the data address and to reserved control bits must leave no trace, and the three-edge latency must line up with two synchronizer flops and one sample stage.

// File: rtl/din_deb_pkg.sv
package din_deb_pkg;
  localparam int unsigned NUM_CH     = 30;
  localparam int unsigned REG_W      = 32;
  localparam int unsigned SEL_W      = 3;
  localparam int unsigned SHIFT_BASE = 6;
  localparam int unsigned SHIFT_STEP = 2;
  localparam int unsigned CNT_W      = SHIFT_BASE + SHIFT_STEP * ((1 << SEL_W) - 1);
  localparam int unsigned EN_BIT     = 7;
  localparam logic [REG_W-1:0] CTRL_WMASK = 32'h0000_00F7;
  localparam int unsigned ADDR_CTRL  = 0;
  localparam int unsigned ADDR_DATA  = 1;

  // terminal count (period - 1) for a rate select
  function automatic logic [CNT_W-1:0] period_m1(input logic [SEL_W-1:0] sel);
    int unsigned sh;
    if (sel == '0) return '0;
    sh = SHIFT_BASE + SHIFT_STEP * int'(sel);
    return CNT_W'((64'd1 << sh) - 64'd1);
  endfunction
endpackage

// File: rtl/deb_ctrl_regs.sv
module deb_ctrl_regs
  import din_deb_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned CH_W   = NUM_CH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic [CH_W-1:0]   data_i,
  output logic              enable_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic              ctrl_wr_o,
  output logic [REG_W-1:0]  rdata_o
);
  logic [REG_W-1:0] ctrl_q;

  assign ctrl_wr_o = we_i && (addr_i == ADDR_W'(ADDR_CTRL));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ctrl_q <= '0;
    else if (ctrl_wr_o) ctrl_q <= wdata_i & CTRL_WMASK;
  end

  assign enable_o = ctrl_q[EN_BIT];
  assign sel_o    = ctrl_q[SEL_W-1:0];

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(ADDR_CTRL))      rdata_o = ctrl_q;
    else if (addr_i == ADDR_W'(ADDR_DATA)) rdata_o = REG_W'(data_i);
  end
endmodule

// File: rtl/deb_tick_gen.sv
module deb_tick_gen
  import din_deb_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             restart_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             at_end;

  assign at_end = (cnt_q == period_m1(sel_i));
  assign tick_o = enable_i && !restart_i && at_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (!enable_i || restart_i)  cnt_q <= '0;
    else if (at_end)                  cnt_q <= '0;
    else                              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/deb_chan_filter.sv
module deb_chan_filter #(
  parameter int unsigned CH_W = 30
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [CH_W-1:0] in_i,
  input  logic            tick_i,
  output logic [CH_W-1:0] data_o
);
  for (genvar c = 0; c < CH_W; c++) begin : g_ch
    logic sync1_q, sync2_q, samp_q, data_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sync1_q <= 1'b0;
        sync2_q <= 1'b0;
      end else begin
        sync1_q <= in_i[c];
        sync2_q <= sync1_q;
      end
    end

    // accept only when this sample repeats the previous one
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        samp_q <= 1'b0;
        data_q <= 1'b0;
      end else if (tick_i) begin
        samp_q <= sync2_q;
        if (sync2_q == samp_q) data_q <= sync2_q;
      end
    end

    assign data_o[c] = data_q;
  end
endmodule

// File: rtl/din_debounce.sv
module din_debounce
  import din_deb_pkg::*;
#(
  parameter int unsigned CH_W   = NUM_CH,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CH_W-1:0]   in_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o
);
  logic             enable;
  logic [SEL_W-1:0] sel;
  logic             ctrl_wr;
  logic             tick;
  logic [CH_W-1:0]  data;

  deb_ctrl_regs #(.ADDR_W(ADDR_W), .CH_W(CH_W)) i_regs (
    .clk_i, .rst_ni, .addr_i, .we_i, .wdata_i,
    .data_i   (data),
    .enable_o (enable),
    .sel_o    (sel),
    .ctrl_wr_o(ctrl_wr),
    .rdata_o
  );

  deb_tick_gen i_tick (
    .clk_i, .rst_ni,
    .enable_i (enable),
    .restart_i(ctrl_wr),
    .sel_i    (sel),
    .tick_o   (tick)
  );

  deb_chan_filter #(.CH_W(CH_W)) i_filt (
    .clk_i, .rst_ni, .in_i,
    .tick_i(tick),
    .data_o(data)
  );
endmodule

// File: rtl/deb_debounce_chk.sv
module deb_debounce_chk
  import din_deb_pkg::*;
#(
  parameter int unsigned CH_W   = NUM_CH,
  parameter int unsigned ADDR_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic [REG_W-1:0]  wdata_i,
  input logic [REG_W-1:0]  rdata_i,
  input logic              enable_i,
  input logic [SEL_W-1:0]  sel_i,
  input logic              tick_i,
  input logic [CH_W-1:0]   data_i
);
  logic ctrl_wr;
  assign ctrl_wr = we_i && (addr_i == ADDR_W'(ADDR_CTRL));

  assert_reserved_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(ADDR_CTRL)) |-> (rdata_i[REG_W-1:8] == '0 && !rdata_i[3]));

  assert_data_pad_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(ADDR_DATA)) |-> (rdata_i[REG_W-1:CH_W] == '0));

  assert_no_tick_off_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |-> !tick_i);

  assert_undivided_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && sel_i == '0 && !ctrl_wr) |-> tick_i);

  assert_hold_between_ticks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(data_i));

  assert_restart_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && wdata_i[SEL_W-1:0] != '0) |=> !tick_i);
endmodule

bind din_debounce deb_debounce_chk #(.CH_W(CH_W), .ADDR_W(ADDR_W)) i_chk (
  .clk_i, .rst_ni, .addr_i, .we_i, .wdata_i,
  .rdata_i (rdata_o),
  .enable_i(enable),
  .sel_i   (sel),
  .tick_i  (tick),
  .data_i  (data)
);

// File: tb/test_din_debounce.sv
`timescale 1ns/1ps
module test_din_debounce;
  localparam int unsigned CH_W = 30;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [CH_W-1:0] in_s = '0;
  logic [1:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  din_debounce i_din_debounce (
    .clk_i(clk), .rst_ni(rst_n), .in_i(in_s),
    .addr_i(addr), .we_i(we), .wdata_i(wdata), .rdata_o(rdata)
  );

  // {write value, expected control readback}
  localparam logic [63:0] VEC [6] = '{
    {32'hFFFF_FFFF, 32'h0000_00F7},
    {32'h0000_0008, 32'h0000_0000},
    {32'h1234_5678, 32'h0000_0070},
    {32'h0000_00A5, 32'h0000_00A5},
    {32'hFFFF_FF08, 32'h0000_0000},
    {32'h0000_0050, 32'h0000_0050}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk);
    #1;
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; we = 1'b0; in_s = '0;
    edges(2);
    rst_n = 1'b1;
    edges(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    do_reset();

    // R1 reset state
    rd(2'd0, v); chk("R1 ctrl reset", v, 32'h0);
    rd(2'd1, v); chk("R1 data reset", v, 32'h0);

    // R2 vector table: masked write/readback
    for (int i = 0; i < 6; i++) begin
      wr(2'd0, VEC[i][63:32]);
      rd(2'd0, v);
      chk("R2 ctrl readback", v, VEC[i][31:0]);
    end
    wr(2'd0, 32'h0);

    // R6/R10: shared tick and three-edge latency at select 000
    wr(2'd0, 32'h0000_0080);
    in_s = 30'h2AAA_5555;
    edges(8);
    rd(2'd1, v); chk("R6 multi-channel capture", v, 32'h2AAA_5555);
    chk("R2 data pad bits", {v[31:30], 30'h0}, 32'h0);
    @(negedge clk); in_s = 30'h1555_AAAA;
    edges(3);
    rd(2'd1, v); chk("R10 not yet after E2", v, 32'h2AAA_5555);
    edges(1);
    rd(2'd1, v); chk("R10 R6 all channels after E3", v, 32'h1555_AAAA);

    // R7 one-cycle pulse rejected, two-cycle accepted
    @(negedge clk); in_s = '0;
    edges(8);
    @(negedge clk); in_s = 30'h1;
    @(negedge clk); in_s = 30'h0;
    edges(8);
    rd(2'd1, v); chk("R7 one-cycle pulse rejected", v, 32'h0);
    @(negedge clk); in_s = 30'h1;
    @(negedge clk);
    @(negedge clk); in_s = 30'h0;
    edges(2);
    rd(2'd1, v); chk("R7 two-cycle pulse accepted", v, 32'h1);
    edges(8);

    // R4 hold while disabled
    @(negedge clk); in_s = 30'h0F0F_0F0F;
    edges(8);
    wr(2'd0, 32'h0);
    @(negedge clk); in_s = 30'h30F0_F0F0;
    edges(30);
    rd(2'd1, v); chk("R4 data held while disabled", v, 32'h0F0F_0F0F);

    // R3 writes to data address ignored
    wr(2'd1, 32'hFFFF_FFFF);
    edges(2);
    rd(2'd1, v); chk("R3 data unchanged", v, 32'h0F0F_0F0F);
    rd(2'd0, v); chk("R3 ctrl unchanged", v, 32'h0);

    // R5 select 001: period 256, level lands at 2N
    do_reset();
    in_s = 30'h1;
    edges(4);
    wr(2'd0, 32'h0000_0081);
    edges(511);
    rd(2'd1, v); chk("R5 sel1 before 2N", v, 32'h0);
    edges(1);
    rd(2'd1, v); chk("R5 sel1 at 2N", v, 32'h1);

    // R5 select 010: period 1024
    do_reset();
    in_s = 30'h2;
    edges(4);
    wr(2'd0, 32'h0000_0082);
    edges(2047);
    rd(2'd1, v); chk("R5 sel2 before 2N", v, 32'h0);
    edges(1);
    rd(2'd1, v); chk("R5 sel2 at 2N", v, 32'h2);

    // R9 rewrite restarts the prescaler
    do_reset();
    in_s = 30'h4;
    edges(4);
    wr(2'd0, 32'h0000_0081);
    edges(199);
    wr(2'd0, 32'h0000_0081);
    edges(400);
    rd(2'd1, v); chk("R9 no early capture after restart", v, 32'h0);
    edges(111);
    rd(2'd1, v); chk("R9 before 2N from rewrite", v, 32'h0);
    edges(1);
    rd(2'd1, v); chk("R9 at 2N from rewrite", v, 32'h4);

    // R8 select 001: short pulse rejected, steady level accepted
    do_reset();
    wr(2'd0, 32'h0000_0081);
    edges(50);
    @(negedge clk); in_s = 30'h8;
    edges(200);
    @(negedge clk); in_s = 30'h0;
    edges(1000);
    rd(2'd1, v); chk("R8 200-cycle pulse rejected", v, 32'h0);
    @(negedge clk); in_s = 30'h8;
    edges(2 * 256 + 260);
    rd(2'd1, v); chk("R8 steady level accepted", v, 32'h8);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule